// File: doc/BRIEF.md
# Postfix Register Stack Unit

This block holds eight 80-bit entries organised as a last-in first-out stack and executes one postfix instruction per clock. Loads and a zero constant push new entries. A store pops the top entry and presents it on a store port. Negation flips the sign of the top entry. Four arithmetic operations (add, subtract, multiply, divide) either fold the two top entries into one, or combine the top entry with an external operand in place. Each arithmetic operation can also run with its two operands swapped.

Each entry has three fields: a sign bit, a 15-bit exponent and a 64-bit fraction. Negation acts only on the sign. Arithmetic treats the fraction as a signed two's-complement integer, so there is no floating-point datapath. Memory is represented only by the operand input and the store output.

The stack never stalls. A push into a full stack succeeds and evicts the oldest entry. An instruction that needs more entries than are present raises a sticky fault and is otherwise ignored. The stack depth and the fault flag are visible as status outputs.

Top module: `regStackCore`

## Requirements
- R1: After reset (`rstN` low), `depth` is 0, `fault` is 0 and `storeValid` is 0.
- R2: Opcode 1 (load) pushes `operand` as the new top and raises `depth` by one. Opcode 3 (store) drives the top entry on `storeData` with `storeValid` high in the cycle after issue, removes that entry and lowers `depth` by one. Entries come back newest first.
- R3: A push into a stack that already holds 8 entries succeeds and `depth` stays 8. The oldest entry is lost, so eight stores then return the eight newest values.
- R4: Opcode 2 pushes an entry with all 80 bits clear.
- R5: Opcode 4 (negate) inverts bit 79 (the sign) of the top entry. Bits 78..64 (exponent) and 63..0 (fraction) are unchanged, and so is `depth`.
- R6: Opcodes 8, 9, 10 and 11 are add, subtract, multiply and divide. With `instMem` low they take the top entry T and the next entry N and compute T op N on the signed 64-bit fractions. The multiply result is the low 64 bits of the product. Both inputs are replaced by one entry whose fraction is the result and whose sign and exponent fields are zero, so `depth` drops by one.
- R7: With `instRev` high an arithmetic operation swaps its operands: N op T on the stack, or X op T in memory form.
- R8: With `instMem` high an arithmetic operation computes T op X, where X is the fraction of `operand`. The top entry is replaced by the result and `depth` is unchanged.
- R9: Division truncates toward zero. A zero divisor gives a zero fraction.
- R10: Store, negate or memory-form arithmetic on an empty stack, or stack-form arithmetic with fewer than 2 entries, sets `fault`. The stack contents and `depth` are left unchanged and no store is emitted. `fault` stays set until reset.
- R11: One instruction is accepted every cycle. Back-to-back instructions each take effect in order, and opcodes not listed above do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| instValid | input | 1 | Instruction present this cycle |
| instOp | input | 4 | Opcode |
| instMem | input | 1 | Arithmetic uses `operand` instead of the second entry |
| instRev | input | 1 | Swap arithmetic operand order |
| operand | input | 80 | Load value, or memory-form operand (fraction used) |
| storeData | output | 80 | Entry popped by the last store |
| storeValid | output | 1 | `storeData` is new this cycle |
| depth | output | 4 | Number of occupied entries, 0 to 8 |
| fault | output | 1 | Sticky underflow fault |

## Verification
Two things can happen in the same cycle: a push that writes the new top and the eviction of the bottom entry, because on a full stack both land in the same physical slot. The bench provokes this with nine back-to-back loads. It then drains the stack and compares each popped value against a queue-based model, so losing the wrong entry, or corrupting the new one, shows up as a mismatch. A second collision is an underflowing fold issued while one entry is still live. The bench judges it by checking that the fault rises and that the following store still returns that entry intact.

// File: rtl/regStackPkg.sv
package regStackPkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_ZERO  = 4'd2,
    OP_STORE = 4'd3,
    OP_NEG   = 4'd4,
    OP_ADD   = 4'd8,
    OP_SUB   = 4'd9,
    OP_MUL   = 4'd10,
    OP_DIV   = 4'd11
  } opCode_e;

  typedef enum logic [1:0] {
    SRC_OPND = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_NEG  = 2'd2,
    SRC_ALU  = 2'd3
  } wrSrc_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_MUL = 2'd2,
    FN_DIV = 2'd3
  } aluFn_e;

  // control -> datapath strobes for one accepted instruction
  typedef struct packed {
    logic   push;      // new top above current top
    logic   popOne;    // drop top without writing
    logic   fold;      // drop two, write one
    logic   writeTop;  // overwrite top in place
    logic   emit;      // copy top to store port
    wrSrc_e src;
    aluFn_e fn;
    logic   rev;
    logic   useMem;
  } strobe_t;

endpackage

// File: rtl/regStackAlu.sv
module regStackAlu
  import regStackPkg::*;
#(
  parameter int FRAC_W = 64
) (
  input  aluFn_e              fn,
  input  logic [FRAC_W-1:0]   lhs,
  input  logic [FRAC_W-1:0]   rhs,
  output logic [FRAC_W-1:0]   result
);

  logic signed [FRAC_W-1:0] sLhs;
  logic signed [FRAC_W-1:0] sRhs;
  logic signed [FRAC_W-1:0] quot;

  assign sLhs = lhs;
  assign sRhs = rhs;

  // signed division truncates toward zero; zero divisor yields zero
  always_comb begin
    if (rhs == '0) quot = '0;
    else           quot = sLhs / sRhs;
  end

  always_comb begin
    unique case (fn)
      FN_ADD:  result = lhs + rhs;
      FN_SUB:  result = lhs - rhs;
      FN_MUL:  result = lhs * rhs;
      default: result = quot;
    endcase
  end

endmodule

// File: rtl/regStackCtrl.sv
module regStackCtrl
  import regStackPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [3:0]       instOp,
  input  logic             instMem,
  input  logic             instRev,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] depth,
  output logic             fault
);

  strobe_t          req;
  logic [CNT_W-1:0] need;
  logic             known;
  logic             underflow;
  logic             go;

  always_comb begin
    req        = '0;
    req.src    = SRC_OPND;
    req.fn     = aluFn_e'(instOp[1:0]);
    req.rev    = instRev;
    req.useMem = instMem;
    need       = '0;
    known      = 1'b1;
    case (instOp)
      OP_LOAD: begin
        req.push = 1'b1;
        req.src  = SRC_OPND;
      end
      OP_ZERO: begin
        req.push = 1'b1;
        req.src  = SRC_ZERO;
      end
      OP_STORE: begin
        req.popOne = 1'b1;
        req.emit   = 1'b1;
        need       = CNT_W'(1);
      end
      OP_NEG: begin
        req.writeTop = 1'b1;
        req.src      = SRC_NEG;
        need         = CNT_W'(1);
      end
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
        req.src = SRC_ALU;
        if (instMem) begin
          req.writeTop = 1'b1;
          need         = CNT_W'(1);
        end else begin
          req.fold = 1'b1;
          need     = CNT_W'(2);
        end
      end
      default: known = 1'b0;
    endcase
  end

  assign underflow = instValid && known && (depth < need);
  assign go        = instValid && known && !underflow;
  assign strobe    = go ? req : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
      fault <= 1'b0;
    end else begin
      if (underflow) fault <= 1'b1;
      if (strobe.push) begin
        if (depth != CNT_W'(DEPTH)) depth <= depth + 1'b1;
      end else if (strobe.popOne || strobe.fold) begin
        depth <= depth - 1'b1;
      end
    end
  end

endmodule

// File: rtl/regStackData.sv
module regStackData
  import regStackPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 64,
  localparam int ENTRY_W = 1 + EXP_W + FRAC_W,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [ENTRY_W-1:0] operand,
  output logic [ENTRY_W-1:0] storeData,
  output logic               storeValid
);

  logic [ENTRY_W-1:0] entries [DEPTH];
  logic [PTR_W-1:0]   topPtr;
  logic [PTR_W-1:0]   ptrUp;
  logic [PTR_W-1:0]   ptrDn;
  logic [PTR_W-1:0]   wrIdx;
  logic               wrEn;
  logic [ENTRY_W-1:0] wrData;
  logic [ENTRY_W-1:0] st0;
  logic [ENTRY_W-1:0] st1;
  logic [FRAC_W-1:0]  opA;
  logic [FRAC_W-1:0]  opB;
  logic [FRAC_W-1:0]  aluOut;

  // pointer arithmetic wraps modulo DEPTH (power of two)
  assign ptrUp = topPtr + 1'b1;
  assign ptrDn = topPtr - 1'b1;
  assign st0   = entries[topPtr];
  assign st1   = entries[ptrUp];

  always_comb begin
    logic [FRAC_W-1:0] other;
    other = strobe.useMem ? operand[FRAC_W-1:0] : st1[FRAC_W-1:0];
    if (strobe.rev) begin
      opA = other;
      opB = st0[FRAC_W-1:0];
    end else begin
      opA = st0[FRAC_W-1:0];
      opB = other;
    end
  end

  regStackAlu #(.FRAC_W(FRAC_W)) alu (
    .fn     (strobe.fn),
    .lhs    (opA),
    .rhs    (opB),
    .result (aluOut)
  );

  always_comb begin
    unique case (strobe.src)
      SRC_OPND: wrData = operand;
      SRC_ZERO: wrData = '0;
      SRC_NEG:  wrData = {~st0[ENTRY_W-1], st0[ENTRY_W-2:0]};
      default:  wrData = {{(1 + EXP_W){1'b0}}, aluOut};
    endcase
  end

  assign wrEn  = strobe.push || strobe.fold || strobe.writeTop;
  assign wrIdx = strobe.push ? ptrDn : (strobe.fold ? ptrUp : topPtr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
    end else if (wrEn) begin
      entries[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr     <= '0;
      storeValid <= 1'b0;
      storeData  <= '0;
    end else begin
      if (strobe.push)                     topPtr <= ptrDn;
      else if (strobe.popOne || strobe.fold) topPtr <= ptrUp;
      storeValid <= strobe.emit;
      if (strobe.emit) storeData <= st0;
    end
  end

endmodule

// File: rtl/regStackCore.sv
module regStackCore
  import regStackPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 64,
  localparam int ENTRY_W = 1 + EXP_W + FRAC_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [3:0]         instOp,
  input  logic               instMem,
  input  logic               instRev,
  input  logic [ENTRY_W-1:0] operand,
  output logic [ENTRY_W-1:0] storeData,
  output logic               storeValid,
  output logic [CNT_W-1:0]   depth,
  output logic               fault
);

  strobe_t strobe;

  regStackCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instOp    (instOp),
    .instMem   (instMem),
    .instRev   (instRev),
    .strobe    (strobe),
    .depth     (depth),
    .fault     (fault)
  );

  regStackData #(.DEPTH(DEPTH), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .operand    (operand),
    .storeData  (storeData),
    .storeValid (storeValid)
  );

endmodule

// File: rtl/regStackChecker.sv
module regStackChecker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic [3:0]       instOp,
  input logic             instMem,
  input logic [CNT_W-1:0] depth,
  input logic             fault,
  input logic             storeValid
);

  logic isArith;
  logic isPush;
  assign isArith = instValid && (instOp[3:2] == 2'b10);
  assign isPush  = instValid && (instOp == 4'd1 || instOp == 4'd2);

  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    depth <= CNT_W'(DEPTH));

  assert_full_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    isPush && depth == CNT_W'(DEPTH) |=> depth == CNT_W'(DEPTH));

  assert_store_pop_R2: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instOp == 4'd3 && depth != '0 |=> storeValid && depth == CNT_W'($past(depth) - 1'b1));

  assert_neg_depth_R5: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instOp == 4'd4 && depth != '0 |=> $stable(depth));

  assert_fold_depth_R6: assert property (@(posedge clk) disable iff (!rstN)
    isArith && !instMem && depth >= CNT_W'(2) |=> depth == CNT_W'($past(depth) - 1'b1));

  assert_mem_depth_R8: assert property (@(posedge clk) disable iff (!rstN)
    isArith && instMem && depth != '0 |=> $stable(depth));

  assert_underflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instOp == 4'd3 && depth == '0 |=> fault && !storeValid && $stable(depth));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

endmodule

bind regStackCore regStackChecker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .instValid  (instValid),
  .instOp     (instOp),
  .instMem    (instMem),
  .depth      (depth),
  .fault      (fault),
  .storeValid (storeValid)
);

// File: tb/regStackCore_test.sv
`timescale 1ns/1ps
module regStackCore_test;

  localparam int W = 80;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instValid = 1'b0;
  logic [3:0]   instOp = '0;
  logic         instMem = 1'b0;
  logic         instRev = 1'b0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] storeData;
  logic         storeValid;
  logic [3:0]   depth;
  logic         fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] mStk[$];
  bit           mFault = 1'b0;
  logic [W-1:0] expQ[$];
  string        tagQ[$];

  always #5 clk = ~clk;

  regStackCore uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instMem(instMem), .instRev(instRev), .operand(operand),
    .storeData(storeData), .storeValid(storeValid), .depth(depth), .fault(fault)
  );

  function automatic logic [W-1:0] mk(input bit s, input logic [14:0] e, input logic [63:0] f);
    return {s, e, f};
  endfunction

  function automatic logic [63:0] calc(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
    logic signed [63:0] sa, sb;
    sa = a; sb = b;
    case (op)
      4'd8:  return a + b;
      4'd9:  return a - b;
      4'd10: return a * b;
      default: return (b == 0) ? 64'd0 : 64'(sa / sb);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input bit mem, input bit rev, input logic [W-1:0] opnd, input string tag);
    int n;
    n = mStk.size();
    case (op)
      4'd1, 4'd2: begin
        if (n == 8) void'(mStk.pop_back());
        mStk.push_front(op == 4'd1 ? opnd : '0);
      end
      4'd3: if (n < 1) mFault = 1'b1;
            else begin expQ.push_back(mStk.pop_front()); tagQ.push_back(tag); end
      4'd4: if (n < 1) mFault = 1'b1;
            else mStk[0][79] = ~mStk[0][79];
      4'd8, 4'd9, 4'd10, 4'd11: begin
        if (n < (mem ? 1 : 2)) mFault = 1'b1;
        else begin
          logic [63:0] t, o, r;
          t = mStk[0][63:0];
          o = mem ? opnd[63:0] : mStk[1][63:0];
          r = rev ? calc(op, o, t) : calc(op, t, o);
          void'(mStk.pop_front());
          if (!mem) void'(mStk.pop_front());
          mStk.push_front({16'h0, r});
        end
      end
      default: ;
    endcase
  endtask

  // driver: one instruction per call, one cycle each
  task automatic issue(input logic [3:0] op, input bit mem, input bit rev, input logic [W-1:0] opnd, input string tag);
    @(negedge clk);
    instValid = 1'b1; instOp = op; instMem = mem; instRev = rev; operand = opnd;
    @(posedge clk);
    model(op, mem, rev, opnd, tag);
    #1;
    check(depth == 4'(mStk.size()), {tag, " depth"}, W'(depth), W'(mStk.size()));
    check(fault == mFault, {tag, " fault"}, W'(fault), W'(mFault));
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0; instOp = '0; instMem = 1'b0; instRev = 1'b0;
  endtask

  // monitor: compare every emitted store against the scoreboard
  always @(negedge clk) begin
    if (rstN && storeValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected store", storeData, '0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(storeData === e, {t, " store"}, storeData, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check(depth == 0, "R1 depth", W'(depth), '0);
    check(fault == 0, "R1 fault", W'(fault), '0);
    check(storeValid == 0, "R1 storeValid", W'(storeValid), '0);

    // R2 R11: back-to-back loads and stores, LIFO order
    issue(4'd1, 0, 0, mk(0, 15'h3fff, 64'd11), "R2 load");
    issue(4'd1, 0, 0, mk(1, 15'h0001, 64'd22), "R2 load");
    issue(4'd1, 0, 0, mk(0, 15'h7fff, 64'hdead_beef), "R11 load");
    issue(4'd3, 0, 0, '0, "R2 store");
    issue(4'd3, 0, 0, '0, "R11 store");
    issue(4'd5, 0, 0, '0, "R11 unused opcode");
    issue(4'd3, 0, 0, '0, "R2 store");

    // R3: nine pushes into eight slots, bottom evicted
    for (int i = 1; i <= 9; i++) issue(4'd1, 0, 0, mk(i[0], 15'(i * 3), 64'(i * 100)), "R3 push");
    for (int i = 0; i < 8; i++) issue(4'd3, 0, 0, '0, "R3 drain");

    // R4: zero constant
    issue(4'd1, 0, 0, {80{1'b1}}, "R4 load");
    issue(4'd2, 0, 0, {80{1'b1}}, "R4 zero");
    issue(4'd3, 0, 0, '0, "R4 store");
    issue(4'd3, 0, 0, '0, "R4 store");

    // R5: negate touches only the sign
    issue(4'd1, 0, 0, mk(0, 15'h1234, 64'h5), "R5 load");
    issue(4'd4, 0, 0, '0, "R5 neg");
    issue(4'd3, 0, 0, '0, "R5 store");
    issue(4'd1, 0, 0, mk(1, 15'h0abc, 64'h77), "R5 load");
    issue(4'd4, 0, 0, '0, "R5 neg");
    issue(4'd4, 0, 0, '0, "R5 neg");
    issue(4'd3, 0, 0, '0, "R5 store");

    // R6 R7: stack folds, normal and reversed
    issue(4'd1, 0, 0, mk(1, 15'h7, 64'd3), "R6 load");
    issue(4'd1, 0, 0, mk(0, 15'h9, -64'sd7), "R6 load");
    issue(4'd8, 0, 0, '0, "R6 add");
    issue(4'd3, 0, 0, '0, "R6 add store");
    issue(4'd1, 0, 0, mk(0, 0, 64'd3), "R6 load");
    issue(4'd1, 0, 0, mk(0, 0, 64'd10), "R6 load");
    issue(4'd9, 0, 0, '0, "R6 sub");
    issue(4'd1, 0, 0, mk(0, 0, 64'd4), "R7 load");
    issue(4'd9, 0, 1, '0, "R7 sub rev");
    issue(4'd3, 0, 0, '0, "R7 store");
    issue(4'd1, 0, 0, mk(0, 0, -64'sd5), "R6 load");
    issue(4'd1, 0, 0, mk(0, 0, 64'h1_0000_0001), "R6 load");
    issue(4'd10, 0, 0, '0, "R6 mul");
    issue(4'd3, 0, 0, '0, "R6 mul store");

    // R9: division rounding and zero divisor
    issue(4'd1, 0, 0, mk(0, 0, -64'sd7), "R9 load");
    issue(4'd1, 0, 0, mk(0, 0, 64'd100), "R9 load");
    issue(4'd11, 0, 0, '0, "R9 div");
    issue(4'd3, 0, 0, '0, "R9 div store");
    issue(4'd1, 0, 0, mk(0, 0, 64'd100), "R9 load");
    issue(4'd1, 0, 0, mk(0, 0, -64'sd7), "R9 load");
    issue(4'd11, 0, 1, '0, "R9 div rev");
    issue(4'd3, 0, 0, '0, "R9 div rev store");
    issue(4'd1, 0, 0, mk(0, 0, 64'd0), "R9 load");
    issue(4'd1, 0, 0, mk(0, 0, 64'd42), "R9 load");
    issue(4'd11, 0, 0, '0, "R9 div zero");
    issue(4'd3, 0, 0, '0, "R9 div zero store");

    // R8 R7: memory-form operations
    issue(4'd1, 0, 0, mk(1, 15'h55, 64'd20), "R8 load");
    issue(4'd8, 1, 0, mk(1, 15'h7fff, 64'd5), "R8 add mem");
    issue(4'd9, 1, 1, mk(0, 0, 64'd100), "R7 sub mem rev");
    issue(4'd10, 1, 0, mk(0, 0, -64'sd3), "R8 mul mem");
    issue(4'd3, 0, 0, '0, "R8 store");

    // R10: underflow with one live entry, then on empty stack
    issue(4'd1, 0, 0, mk(0, 15'h2, 64'h1234), "R10 load");
    issue(4'd8, 0, 0, '0, "R10 fold underflow");
    issue(4'd3, 0, 0, '0, "R10 store after fault");
    issue(4'd3, 0, 0, '0, "R10 store empty");
    issue(4'd4, 0, 0, '0, "R10 neg empty");
    issue(4'd8, 1, 0, mk(0, 0, 64'd1), "R10 mem op empty");
    issue(4'd1, 0, 0, mk(0, 0, 64'd9), "R10 load after fault");
    issue(4'd3, 0, 0, '0, "R10 store after fault");
    idle();
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 pending stores", W'(expQ.size()), '0);
    check(fault == 1'b1, "R10 sticky", W'(fault), W'(1));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule